// File: doc/BRIEF.md
# SDRAM Read-Latency Data Pipeline

This block sits between a memory controller's command issue logic and the 32-bit data bus of a synchronous DRAM. It sees read, write and precharge issue pulses together with a burst length code. From these it expands each command into a run of data beats. For every read beat it raises a capture strobe in the exact cycle the word arrives on the bus, which is two or three cycles after the beat is issued depending on the programmed read latency.

It also places the byte-mask pins in time. A mask for a read beat has to reach the memory two cycles before the word it blanks. A mask for a write beat goes out in the same cycle as the data. The block drives the controller's bus-drive enable for write beats and keeps that enable low in any cycle that carries returning read data. The controller gives each beat's mask together with the beat. The block then shifts it to the cycle the memory expects.

Top module: `sdram_rdlat_pipe`

## Requirements
- R1: With latency setting 2 (`lat_long`=0), a read beat issued in cycle t raises `rd_valid` in cycle t+2 and only then.
- R2: With latency setting 3 (`lat_long`=1), a read beat issued in cycle t raises `rd_valid` in cycle t+3 and only then.
- R3: A new `lat_long` value takes effect one cycle after a cycle in which no read is in flight: none issued, none pending in the burst and none in the pipeline. Reads already issued keep the latency they started with.
- R4: `burst_code` value k, sampled with a command, produces 2^k consecutive beats (1, 2, 4 or 8), the first in the command cycle.
- R5: A read or write command interrupts any burst and starts its own. When commands coincide the priority is read, then write, then precharge.
- R6: A precharge with no read or write in the same cycle ends the current burst. No beat is issued in that cycle or later, so read data stops before the precharge cycle plus the latency.
- R7: `mask_req` bit i, given with a read beat, appears on `dqm_out` bit i exactly 2 cycles before that beat's data cycle. In the data cycle, `rd_byte_en` bit i equals the inverse of that mask bit. `rd_byte_en` is zero when `rd_valid` is low.
- R8: `mask_req`, given with a write beat, appears on `dqm_out` in the same cycle.
- R9: `bus_drive_en` is high only in write-beat cycles and never while `rd_valid` is high. When a read mask slot and a write beat share a cycle, the read mask wins on `dqm_out`.
- R10: During reset and just after it, all outputs are low and the latency setting is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_cmd | input | 1 | Read command issue pulse |
| wr_cmd | input | 1 | Write command issue pulse |
| pre_cmd | input | 1 | Precharge command issue pulse |
| burst_code | input | 2 | Burst length code, length 2^code |
| lat_long | input | 1 | Latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| mask_req | input | 4 | Per-lane mask for the beat issued this cycle (bit i covers byte lane i) |
| rd_valid | output | 1 | Read data capture strobe |
| rd_byte_en | output | 4 | Unmasked lanes of the word being captured |
| bus_drive_en | output | 1 | Controller drives write data onto the bus |
| dqm_out | output | 4 | Byte-mask pins toward the memory |

## Verification
The bench sweeps both latencies against every burst length with a different mask on each beat. An off-by-one in the pipeline tap would move the strobe or the mask pins by a cycle. It cuts bursts with a precharge and with new commands. A generator that ignored the cut would keep strobing after the precharge or mix beats from two bursts. It changes the latency while a long burst is still draining. A design that applied the change at once would misplace the tail of that burst. It also overlaps a write burst with returning read data. A wrong drive gate there would show `bus_drive_en` high during a read word, or would let the write mask override a read mask slot.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;

  typedef enum logic [0:0] {
    BEAT_RD = 1'b0,
    BEAT_WR = 1'b1
  } beat_kind_e;

endpackage

// File: rtl/sdp_rst_sync.sv
module sdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/sdp_burst_seq.sv
module sdp_burst_seq
  import sdram_dp_pkg::*;
#(
  parameter int MAX_BURST = 8,
  parameter int BC_W      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_cmd,
  input  logic            wr_cmd,
  input  logic            pre_cmd,
  input  logic [BC_W-1:0] burst_code,
  output logic            beat_rd,
  output logic            beat_wr,
  output logic            rd_busy
);

  localparam int CNT_W = $clog2(MAX_BURST);

  logic [CNT_W-1:0] rem_q, rem_d;
  beat_kind_e       kind_q, kind_d;
  logic [CNT_W:0]   blen;
  logic             upd_en;

  // burst length from the code: 1 << code
  assign blen = (CNT_W+1)'(1) << burst_code;

  always_comb begin
    rem_d   = rem_q;
    kind_d  = kind_q;
    beat_rd = 1'b0;
    beat_wr = 1'b0;
    if (rd_cmd) begin
      beat_rd = 1'b1;
      kind_d  = BEAT_RD;
      rem_d   = CNT_W'(blen - 1'b1);
    end else if (wr_cmd) begin
      beat_wr = 1'b1;
      kind_d  = BEAT_WR;
      rem_d   = CNT_W'(blen - 1'b1);
    end else if (pre_cmd) begin
      rem_d   = '0;
    end else if (rem_q != '0) begin
      beat_rd = (kind_q == BEAT_RD);
      beat_wr = (kind_q == BEAT_WR);
      rem_d   = rem_q - 1'b1;
    end
  end

  assign upd_en  = rd_cmd | wr_cmd | pre_cmd | (rem_q != '0);
  assign rd_busy = (rem_q != '0) && (kind_q == BEAT_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      kind_q <= BEAT_RD;
    end else if (upd_en) begin
      rem_q  <= rem_d;
      kind_q <= kind_d;
    end
  end

endmodule

// File: rtl/sdp_lat_ctrl.sv
module sdp_lat_ctrl #(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3,
  parameter int RST_LAT = 3,
  parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_long,
  input  logic             in_flight,
  output logic [LAT_W-1:0] lat_q
);

  logic [LAT_W-1:0] lat_d;
  logic             lat_en;

  assign lat_d  = lat_long ? LAT_W'(MAX_LAT) : LAT_W'(MIN_LAT);
  assign lat_en = !in_flight && (lat_d != lat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= LAT_W'(RST_LAT);
    else if (lat_en) lat_q <= lat_d;
  end

endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe #(
  parameter int LANES     = 4,
  parameter int MAX_LAT   = 3,
  parameter int MASK_LEAD = 2,
  parameter int LAT_W     = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LANES-1:0] in_mask,
  input  logic [LAT_W-1:0] lat_q,
  output logic             tap_v,
  output logic [LANES-1:0] tap_m,
  output logic             lead_v,
  output logic [LANES-1:0] lead_m,
  output logic             pend
);

  // stage k holds the read beat issued k cycles ago; stage 0 is this cycle
  logic             v_all [0:MAX_LAT];
  logic [LANES-1:0] m_all [0:MAX_LAT];
  logic [LAT_W-1:0] lead_idx;
  logic             sh_en;

  assign v_all[0] = in_valid;
  assign m_all[0] = in_mask;

  always_comb begin
    pend = 1'b0;
    for (int k = 1; k <= MAX_LAT; k++) pend = pend | v_all[k];
  end

  assign sh_en = pend | in_valid;

  for (genvar k = 1; k <= MAX_LAT; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_all[k] <= 1'b0;
        m_all[k] <= '0;
      end else if (sh_en) begin
        v_all[k] <= v_all[k-1];
        if (v_all[k-1]) m_all[k] <= m_all[k-1];
      end
    end
  end

  assign lead_idx = lat_q - LAT_W'(MASK_LEAD);
  assign tap_v    = v_all[lat_q];
  assign tap_m    = m_all[lat_q];
  assign lead_v   = v_all[lead_idx];
  assign lead_m   = m_all[lead_idx];

endmodule

// File: rtl/sdp_lane_out.sv
module sdp_lane_out #(
  parameter int LANES = 4
) (
  input  logic             tap_v,
  input  logic [LANES-1:0] tap_m,
  input  logic             lead_v,
  input  logic [LANES-1:0] lead_m,
  input  logic             wr_beat,
  input  logic [LANES-1:0] wr_mask,
  output logic             rd_valid,
  output logic [LANES-1:0] rd_byte_en,
  output logic             bus_drive_en,
  output logic [LANES-1:0] dqm_out
);

  assign rd_valid     = tap_v;
  assign bus_drive_en = wr_beat & ~tap_v;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_byte_en[i] = tap_v & ~tap_m[i];
    assign dqm_out[i]    = lead_v ? lead_m[i] : (wr_beat & wr_mask[i]);
  end

endmodule

// File: rtl/sdram_rdlat_pipe.sv
module sdram_rdlat_pipe #(
  parameter int LANES     = 4,
  parameter int MIN_LAT   = 2,
  parameter int MAX_LAT   = 3,
  parameter int RST_LAT   = 3,
  parameter int MASK_LEAD = 2,
  parameter int MAX_BURST = 8,
  parameter int BC_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  input  logic             pre_cmd,
  input  logic [BC_W-1:0]  burst_code,
  input  logic             lat_long,
  input  logic [LANES-1:0] mask_req,
  output logic             rd_valid,
  output logic [LANES-1:0] rd_byte_en,
  output logic             bus_drive_en,
  output logic [LANES-1:0] dqm_out
);

  localparam int LAT_W = $clog2(MAX_LAT + 1);

  logic             rst_sn;
  logic             beat_rd, beat_wr, rd_busy;
  logic             pend, in_flight;
  logic [LAT_W-1:0] lat_q;
  logic             tap_v, lead_v;
  logic [LANES-1:0] tap_m, lead_m;

  sdp_rst_sync i_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  sdp_burst_seq #(
    .MAX_BURST (MAX_BURST),
    .BC_W      (BC_W)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .rd_cmd     (rd_cmd),
    .wr_cmd     (wr_cmd),
    .pre_cmd    (pre_cmd),
    .burst_code (burst_code),
    .beat_rd    (beat_rd),
    .beat_wr    (beat_wr),
    .rd_busy    (rd_busy)
  );

  assign in_flight = pend | rd_busy | beat_rd;

  sdp_lat_ctrl #(
    .MIN_LAT (MIN_LAT),
    .MAX_LAT (MAX_LAT),
    .RST_LAT (RST_LAT),
    .LAT_W   (LAT_W)
  ) i_lat (
    .clk       (clk),
    .rst_n     (rst_sn),
    .lat_long  (lat_long),
    .in_flight (in_flight),
    .lat_q     (lat_q)
  );

  sdp_rd_pipe #(
    .LANES     (LANES),
    .MAX_LAT   (MAX_LAT),
    .MASK_LEAD (MASK_LEAD),
    .LAT_W     (LAT_W)
  ) i_pipe (
    .clk      (clk),
    .rst_n    (rst_sn),
    .in_valid (beat_rd),
    .in_mask  (mask_req),
    .lat_q    (lat_q),
    .tap_v    (tap_v),
    .tap_m    (tap_m),
    .lead_v   (lead_v),
    .lead_m   (lead_m),
    .pend     (pend)
  );

  sdp_lane_out #(
    .LANES (LANES)
  ) i_out (
    .tap_v        (tap_v),
    .tap_m        (tap_m),
    .lead_v       (lead_v),
    .lead_m       (lead_m),
    .wr_beat      (beat_wr),
    .wr_mask      (mask_req),
    .rd_valid     (rd_valid),
    .rd_byte_en   (rd_byte_en),
    .bus_drive_en (bus_drive_en),
    .dqm_out      (dqm_out)
  );

endmodule

// File: rtl/sdram_rdlat_pipe_chk.sv
module sdram_rdlat_pipe_chk #(
  parameter int LANES   = 4,
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3,
  parameter int LAT_W   = 2
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             rd_cmd,
  input logic             wr_cmd,
  input logic             pre_cmd,
  input logic             beat_rd,
  input logic             beat_wr,
  input logic [LAT_W-1:0] lat_q,
  input logic             rd_valid,
  input logic [LANES-1:0] rd_byte_en,
  input logic             bus_drive_en
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1 and R2: every strobe traces back to a read beat at the current latency
  a_r1_r2_strobe_age: assert property (@(posedge clk) disable iff (!rst_sn)
    (age_q == 2'd3 && rd_valid) |->
      ((lat_q == LAT_W'(MIN_LAT) && $past(beat_rd, 2)) ||
       (lat_q == LAT_W'(MAX_LAT) && $past(beat_rd, 3))));

  a_r3_lat_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    beat_rd |=> $stable(lat_q));

  a_r6_pre_stops: assert property (@(posedge clk) disable iff (!rst_sn)
    (pre_cmd && !rd_cmd && !wr_cmd) |-> (!beat_rd && !beat_wr));

  a_r7_no_lanes_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_valid |-> (rd_byte_en == '0));

  a_r9_no_clash: assert property (@(posedge clk) disable iff (!rst_sn)
    !(bus_drive_en && rd_valid));

  a_r9_drive_on_write: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_drive_en |-> beat_wr);

endmodule

bind sdram_rdlat_pipe sdram_rdlat_pipe_chk #(
  .LANES   (LANES),
  .MIN_LAT (MIN_LAT),
  .MAX_LAT (MAX_LAT),
  .LAT_W   (LAT_W)
) i_chk (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .rd_cmd       (rd_cmd),
  .wr_cmd       (wr_cmd),
  .pre_cmd      (pre_cmd),
  .beat_rd      (beat_rd),
  .beat_wr      (beat_wr),
  .lat_q        (lat_q),
  .rd_valid     (rd_valid),
  .rd_byte_en   (rd_byte_en),
  .bus_drive_en (bus_drive_en)
);

// File: tb/test_sdram_rdlat_pipe.sv
module test_sdram_rdlat_pipe;

  localparam int NC = 24;

  logic       clk, rst_n;
  logic       rd_cmd, wr_cmd, pre_cmd, lat_long;
  logic [1:0] burst_code;
  logic [3:0] mask_req;
  logic       rd_valid, bus_drive_en;
  logic [3:0] rd_byte_en, dqm_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic cur_lat;

  logic       d_rd [NC];
  logic       d_wr [NC];
  logic       d_pre[NC];
  logic       d_lat[NC];
  logic [1:0] d_bc [NC];
  logic [3:0] d_mask[NC];
  logic       rb [NC];
  logic       wb [NC];
  int         lb [NC];

  sdram_rdlat_pipe i_sdram_rdlat_pipe (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .pre_cmd(pre_cmd), .burst_code(burst_code), .lat_long(lat_long),
    .mask_req(mask_req), .rd_valid(rd_valid), .rd_byte_en(rd_byte_en),
    .bus_drive_en(bus_drive_en), .dqm_out(dqm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear(int seed);
    for (int c = 0; c < NC; c++) begin
      d_rd[c] = 0; d_wr[c] = 0; d_pre[c] = 0; d_lat[c] = cur_lat;
      d_bc[c] = 0; d_mask[c] = 4'((c * 7 + seed) & 15);
      rb[c] = 0; wb[c] = 0; lb[c] = 0;
    end
  endtask

  task automatic add_rd(int s, int n, int l);
    for (int b = s; b < s + n; b++) begin rb[b] = 1; lb[b] = l; end
  endtask

  task automatic add_wr(int s, int n);
    for (int b = s; b < s + n; b++) wb[b] = 1;
  endtask

  task automatic run(int n, string tag);
    for (int c = 0; c < n; c++) begin
      logic rv, sv, ebde;
      logic [3:0] rm, sm, edqm, eren;
      @(negedge clk);
      rd_cmd = d_rd[c]; wr_cmd = d_wr[c]; pre_cmd = d_pre[c];
      lat_long = d_lat[c]; burst_code = d_bc[c]; mask_req = d_mask[c];
      #1;
      rv = 0; sv = 0; rm = 0; sm = 0;
      for (int b = 0; b <= c; b++) begin
        if (rb[b] && b + lb[b] == c)     begin rv = 1; rm = d_mask[b]; end
        if (rb[b] && b + lb[b] - 2 == c) begin sv = 1; sm = d_mask[b]; end
      end
      edqm = sv ? sm : (wb[c] ? d_mask[c] : 4'h0);
      eren = rv ? ~rm : 4'h0;
      ebde = wb[c] && !rv;
      chk(tag, "rd_valid", 8'(rd_valid), 8'(rv));
      chk(tag, "rd_byte_en", 8'(rd_byte_en), 8'(eren));
      chk(tag, "dqm_out", 8'(dqm_out), 8'(edqm));
      chk(tag, "bus_drive_en", 8'(bus_drive_en), 8'(ebde));
    end
    cur_lat = d_lat[n-1];
  endtask

  initial begin
    rst_n = 0; rd_cmd = 0; wr_cmd = 0; pre_cmd = 0; lat_long = 1;
    burst_code = 0; mask_req = 0; cur_lat = 1;
    repeat (3) @(negedge clk);
    // R10: outputs low while reset is held
    chk("R10", "rd_valid", 8'(rd_valid), 8'h0);
    chk("R10", "dqm_out", 8'(dqm_out), 8'h0);
    chk("R10", "bus_drive_en", 8'(bus_drive_en), 8'h0);
    chk("R10", "rd_byte_en", 8'(rd_byte_en), 8'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10: latency after reset is 3
    clear(1); d_rd[1] = 1; add_rd(1, 1, 3);
    run(8, "R10");

    // R1, R2, R4, R7: every latency against every burst length
    for (int l = 0; l < 2; l++) begin
      for (int k = 0; k < 4; k++) begin
        clear(k * 3 + l);
        for (int c = 0; c < NC; c++) d_lat[c] = 1'(l);
        d_rd[1] = 1; d_bc[1] = 2'(k);
        add_rd(1, 1 << k, l ? 3 : 2);
        run(16, l ? "R2,R4,R7" : "R1,R4,R7");
      end
    end

    // R6: precharge in cycle 4 cuts an 8-beat read after 3 beats
    for (int l = 0; l < 2; l++) begin
      clear(5 + l);
      for (int c = 0; c < NC; c++) d_lat[c] = 1'(l);
      d_rd[1] = 1; d_bc[1] = 3; d_pre[4] = 1;
      add_rd(1, 3, l ? 3 : 2);
      run(14, "R6");
    end

    // R8: write bursts of each length
    for (int k = 0; k < 4; k++) begin
      clear(9 + k);
      d_wr[1] = 1; d_bc[1] = 2'(k);
      add_wr(1, 1 << k);
      run(12, "R8");
    end

    // R9: write burst overlaps returning read data at latency 3
    clear(2);
    for (int c = 0; c < NC; c++) d_lat[c] = 1;
    d_rd[1] = 1; d_bc[1] = 2; d_wr[3] = 1; d_bc[3] = 2;
    add_rd(1, 2, 3); add_wr(3, 4);
    run(12, "R9");

    // R5: read interrupted by read; read+write and read+precharge coincide
    clear(4);
    for (int c = 0; c < NC; c++) d_lat[c] = 0;
    d_rd[1] = 1; d_bc[1] = 3; d_rd[4] = 1; d_bc[4] = 1;
    add_rd(1, 3, 2); add_rd(4, 2, 2);
    run(12, "R5");
    clear(6);
    d_rd[1] = 1; d_wr[1] = 1; d_bc[1] = 1; add_rd(1, 2, 2);
    d_rd[6] = 1; d_pre[6] = 1; add_rd(6, 1, 2);
    run(12, "R5");

    // R3: latency request changes during a long read, applied only after it drains
    clear(8);
    for (int c = 2; c < NC; c++) d_lat[c] = 1;
    d_rd[1] = 1; d_bc[1] = 3; add_rd(1, 8, 2);
    d_rd[14] = 1; add_rd(14, 1, 3);
    run(22, "R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule